// File: doc/BRIEF.md
# Path-Aware Dependence Violation Filter

This block sits beside one speculative thread's exposed-load tracking. The thread runs ahead of its predecessors, and it may also fork onto both sides of hard-to-predict branches (multi-path mode). Each exposed load is kept as a record holding its address, the thread's version ID, and the direction bits of the context that issued it. A record also holds a mask of the fork levels that were open when it was written. When a predecessor's store lands on a recorded address, the block either asks for a restart at once or holds the violation until the forks settle.

Each fork claims the next direction bit, and forks resolve in the order they were opened. At a resolution, records whose bit for that level differs from the surviving direction are dropped, together with any violation they carry. When the last open fork resolves, the thread restarts only if a surviving record carries a held violation. Stores the thread makes itself are only published outside multi-path mode. A full table makes the thread stall until the stall can be lifted.

Top module: `path_violation_filter`

## Requirements
- R1: Immediately after reset, `restart`, `mp_mode` and `stall` are 0 and no read hits the table.
- R2: A load pulse on `ld_valid` writes a record when a slot is free. `rd_hit` is 1 in the same cycle when a valid record has equal address and equal version, whatever the record's direction bits.
- R3: A store hits a record when the addresses are equal and `st_ver` is less than the record's version (unsigned). Outside multi-path mode, a hit drives `restart` high for exactly the one cycle after the store and empties the table. A store whose `st_ver` is not less than the record's version does not hit.
- R4: An accepted fork sets `mp_mode` from the next cycle. Fork number k since mode entry (counting from 0) owns direction bit k. At most DIR_W forks stay open, and further forks are ignored. `mp_mode` falls when every accepted fork has resolved.
- R5: While `mp_mode` is 1, a store hit does not raise `restart`. The hit is held on the record instead.
- R6: The resolution that closes the last fork raises `restart` in the next cycle exactly when a surviving record holds a violation. A record survives if, at every level open when it was written, its direction bit equals that level's `res_taken`.
- R7: At each resolution, records whose bit for the resolved level differs from `res_taken` are removed, so later reads miss them.
- R8: After `mp_mode` falls without a restart, surviving records behave as normal records, and a later store hit restarts at once.
- R9: `st_publish` follows `own_st_valid` outside multi-path mode and is 0 while `mp_mode` is 1.
- R10: A load that finds every slot in use is not recorded and sets `stall` from the next cycle. `stall` holds until `mp_mode` falls, a commit, or a restart.
- R11: `commit` empties the table, drops held violations and open forks, and clears `stall` without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Exposed load to record |
| ld_addr | input | ADDR_W | Load address |
| ld_ver | input | VER_W | Version ID of the loading thread |
| ld_dir | input | DIR_W | Direction bits of the loading context |
| rd_valid | input | 1 | Ordinary read lookup |
| rd_addr | input | ADDR_W | Read address |
| rd_ver | input | VER_W | Read version ID |
| rd_hit | output | 1 | Read matches a record on address and version |
| st_valid | input | 1 | Store from a predecessor thread |
| st_addr | input | ADDR_W | Store address |
| st_ver | input | VER_W | Store version ID |
| fork_valid | input | 1 | Hard-to-predict branch forks a path |
| res_valid | input | 1 | Oldest open fork resolves |
| res_taken | input | 1 | Surviving direction of that fork |
| own_st_valid | input | 1 | Store issued by this thread |
| st_publish | output | 1 | Own store may leave the store buffer |
| commit | input | 1 | Thread commits, table cleared |
| restart | output | 1 | One-cycle restart request |
| mp_mode | output | 1 | At least one fork is open |
| stall | output | 1 | Table overflowed, thread must wait |

## Verification
Most internal faults show up at the ports within one or two cycles. If a record is tagged with the wrong direction bit, a killed-path load still hits on the next read, or a surviving pending load fails to restart when the last fork closes. If the fork or resolve counters go astray, `mp_mode` stays high after the final resolution, or falls one fork too early. If a held violation is lost or leaks across levels, `restart` has the wrong value in the cycle after the final resolution. A stale pending bit shows up as a restart where none is due.

// File: rtl/path_violation_filter.sv
module path_violation_filter #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  parameter int VER_W   = 4,
  parameter int DIR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [VER_W-1:0]  ld_ver,
  input  logic [DIR_W-1:0]  ld_dir,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [VER_W-1:0]  rd_ver,
  output logic              rd_hit,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [VER_W-1:0]  st_ver,
  input  logic              fork_valid,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              own_st_valid,
  output logic              st_publish,
  input  logic              commit,
  output logic              restart,
  output logic              mp_mode,
  output logic              stall
);
  localparam int LW = $clog2(DIR_W + 1);

  logic [ENTRIES-1:0] v_q, pend_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [VER_W-1:0]   ver_q  [ENTRIES];
  logic [DIR_W-1:0]   dir_q  [ENTRIES];
  logic [DIR_W-1:0]   msk_q  [ENTRIES];
  logic [LW-1:0]      fp_q, rp_q;
  logic               ovf_q, restart_q;

  logic [ENTRIES-1:0] hit, kill, alloc_oh, v_n, pend_n, rd_m;
  logic [DIR_W-1:0]   lvl_oh, mask_new;
  logic               fork_ok, res_ok, full, drop, ld_ok, viol_now, exit_mp, restart_now;
  logic [LW-1:0]      fp_n, rp_n;

  function automatic logic [DIR_W-1:0] below(input logic [LW-1:0] n);
    logic [DIR_W-1:0] m;
    for (int k = 0; k < DIR_W; k++) m[k] = (k < int'(n));
    return m;
  endfunction

  assign mp_mode    = fp_q != rp_q;
  assign st_publish = own_st_valid & ~mp_mode;
  assign stall      = ovf_q;
  assign restart    = restart_q;
  assign rd_hit     = |rd_m;

  assign fork_ok  = fork_valid & (fp_q < LW'(DIR_W));
  assign res_ok   = res_valid & mp_mode;
  assign fp_n     = fp_q + LW'(fork_ok);
  assign rp_n     = rp_q + LW'(res_ok);
  assign lvl_oh   = DIR_W'(1) << rp_q;
  assign mask_new = below(fp_q) & ~below(rp_n);
  assign full     = &v_q;
  assign drop     = res_ok & ((|(ld_dir & lvl_oh)) != res_taken);
  assign ld_ok    = ld_valid & ~full & ~drop;
  assign viol_now = ~mp_mode & (|hit);
  assign exit_mp  = mp_mode & (fp_n == rp_n);

  always_comb begin
    alloc_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      rd_m[i] = rd_valid & v_q[i] & (addr_q[i] == rd_addr) & (ver_q[i] == rd_ver);
      hit[i]  = st_valid & v_q[i] & (addr_q[i] == st_addr) & (st_ver < ver_q[i]);
      kill[i] = res_ok & v_q[i] & (|(msk_q[i] & lvl_oh)) &
                ((|(dir_q[i] & lvl_oh)) != res_taken);
      if (!v_q[i] && alloc_oh == '0) alloc_oh[i] = 1'b1;
    end
    v_n    = (v_q & ~kill) | (ld_ok ? alloc_oh : '0);
    pend_n = (pend_q | (mp_mode ? hit : '0)) & ~kill;
    restart_now = exit_mp & (|(pend_n & v_q & ~kill));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; pend_q <= '0; fp_q <= '0; rp_q <= '0;
      ovf_q <= 1'b0; restart_q <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        addr_q[i] <= '0; ver_q[i] <= '0; dir_q[i] <= '0; msk_q[i] <= '0;
      end
    end else if (viol_now || commit) begin
      v_q <= '0; pend_q <= '0; fp_q <= '0; rp_q <= '0;
      ovf_q <= 1'b0; restart_q <= viol_now;
    end else begin
      restart_q <= restart_now;
      for (int i = 0; i < ENTRIES; i++) begin
        if (ld_ok && alloc_oh[i]) begin
          addr_q[i] <= ld_addr;
          ver_q[i]  <= ld_ver;
          dir_q[i]  <= ld_dir;
          msk_q[i]  <= mask_new;
        end
      end
      if (exit_mp) begin
        v_q    <= restart_now ? '0 : v_n;
        pend_q <= '0;
        fp_q   <= '0;
        rp_q   <= '0;
        ovf_q  <= 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
          dir_q[i] <= '0;
          msk_q[i] <= '0;
        end
      end else begin
        v_q    <= v_n;
        pend_q <= pend_n;
        fp_q   <= fp_n;
        rp_q   <= rp_n;
        if (ld_valid && full) ovf_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/path_violation_filter_chk.sv
module path_violation_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic fork_valid,
  input logic res_valid,
  input logic commit,
  input logic restart,
  input logic mp_mode,
  input logic stall
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!restart && !mp_mode && !stall));
  a_r3_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
  a_r5_no_restart_in_mp: assert property (@(posedge clk) disable iff (!rst_n)
    mp_mode |-> !restart);
  a_r4_enter_by_fork: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mp_mode) |-> $past(fork_valid));
  a_r4_leave_by_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mp_mode) |-> $past(res_valid || commit));
  a_r10_stall_released: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mp_mode) |-> !stall);
endmodule

bind path_violation_filter path_violation_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fork_valid(fork_valid), .res_valid(res_valid),
  .commit(commit), .restart(restart), .mp_mode(mp_mode), .stall(stall)
);

// File: tb/sim_path_violation_filter.sv
`timescale 1ns/1ps
module sim_path_violation_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, rd_valid = 0, st_valid = 0, fork_valid = 0, res_valid = 0;
  logic res_taken = 0, own_st_valid = 0, commit = 0;
  logic [7:0] ld_addr = 0, rd_addr = 0, st_addr = 0;
  logic [3:0] ld_ver = 0, rd_ver = 0, st_ver = 0;
  logic [2:0] ld_dir = 0;
  logic rd_hit, st_publish, restart, mp_mode, stall;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  path_violation_filter #(.ENTRIES(4), .ADDR_W(8), .VER_W(4), .DIR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ver(ld_ver),
    .ld_dir(ld_dir), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ver(rd_ver),
    .rd_hit(rd_hit), .st_valid(st_valid), .st_addr(st_addr), .st_ver(st_ver),
    .fork_valid(fork_valid), .res_valid(res_valid), .res_taken(res_taken),
    .own_st_valid(own_st_valid), .st_publish(st_publish), .commit(commit),
    .restart(restart), .mp_mode(mp_mode), .stall(stall));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic do_load(input logic [7:0] a, input logic [3:0] v, input logic [2:0] d);
    ld_valid = 1; ld_addr = a; ld_ver = v; ld_dir = d; tick(); ld_valid = 0;
  endtask
  task automatic do_store(input logic [7:0] a, input logic [3:0] v);
    st_valid = 1; st_addr = a; st_ver = v; tick(); st_valid = 0;
  endtask
  task automatic do_fork; fork_valid = 1; tick(); fork_valid = 0; endtask
  task automatic do_res(input logic t); res_valid = 1; res_taken = t; tick(); res_valid = 0; endtask
  task automatic do_commit; commit = 1; tick(); commit = 0; endtask
  task automatic read_chk(input string tag, input logic [7:0] a, input logic [3:0] v, input logic exp);
    rd_valid = 1; rd_addr = a; rd_ver = v; #1; check(tag, rd_hit, exp); rd_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 restart", restart, 0);
    check("R1 mp_mode", mp_mode, 0);
    check("R1 stall", stall, 0);
    read_chk("R1 empty table", 8'h00, 4'h0, 0);
  endtask

  task automatic t_normal;
    do_load(8'h10, 4'd5, 3'b000);
    read_chk("R2 read hit", 8'h10, 4'd5, 1);
    read_chk("R2 version mismatch", 8'h10, 4'd4, 0);
    read_chk("R2 address mismatch", 8'h11, 4'd5, 0);
    do_store(8'h10, 4'd5);
    check("R3 equal version no hit", restart, 0);
    do_store(8'h10, 4'd3);
    check("R3 immediate restart", restart, 1);
    tick();
    check("R3 restart one cycle", restart, 0);
    read_chk("R3 table emptied", 8'h10, 4'd5, 0);
  endtask

  task automatic t_kill_path;
    do_fork();
    check("R4 mp after fork", mp_mode, 1);
    do_load(8'h20, 4'd5, 3'b001);
    do_load(8'h21, 4'd5, 3'b000);
    read_chk("R2 read ignores dir", 8'h20, 4'd5, 1);
    do_store(8'h20, 4'd2);
    check("R5 held in mp", restart, 0);
    check("R5 still mp", mp_mode, 1);
    do_res(1'b0);
    check("R4 mp exit", mp_mode, 0);
    check("R6 killed pending no restart", restart, 0);
    read_chk("R7 killed record gone", 8'h20, 4'd5, 0);
    read_chk("R7 survivor kept", 8'h21, 4'd5, 1);
    do_store(8'h21, 4'd2);
    check("R8 survivor normal restart", restart, 1);
    tick();
  endtask

  task automatic t_survivor_restart;
    do_fork();
    do_load(8'h30, 4'd6, 3'b001);
    do_store(8'h30, 4'd1);
    check("R5 no restart in mp", restart, 0);
    do_res(1'b1);
    check("R6 survivor pending restarts", restart, 1);
    check("R6 mp left", mp_mode, 0);
    tick();
  endtask

  task automatic t_nested;
    do_fork();
    do_load(8'h41, 4'd6, 3'b000);
    do_fork();
    do_load(8'h40, 4'd6, 3'b010);
    do_store(8'h41, 4'd1);
    do_store(8'h40, 4'd1);
    check("R5 nested held", restart, 0);
    do_res(1'b0);
    check("R4 one fork still open", mp_mode, 1);
    check("R5 no restart mid", restart, 0);
    read_chk("R7 level1 record alive", 8'h40, 4'd6, 1);
    do_res(1'b0);
    check("R6 pre-fork record survives", restart, 1);
    check("R4 nested exit", mp_mode, 0);
    tick();
  endtask

  task automatic t_fork_limit;
    for (int i = 0; i < 4; i++) do_fork();
    do_res(1'b0); do_res(1'b0);
    check("R4 open after two", mp_mode, 1);
    do_res(1'b0);
    check("R4 fourth fork ignored", mp_mode, 0);
    check("R6 nothing pending", restart, 0);
  endtask

  task automatic t_publish;
    own_st_valid = 1; #1;
    check("R9 publish normal", st_publish, 1);
    own_st_valid = 0;
    do_fork();
    own_st_valid = 1; #1;
    check("R9 held in mp", st_publish, 0);
    own_st_valid = 0;
    do_res(1'b0);
    own_st_valid = 1; #1;
    check("R9 publish after exit", st_publish, 1);
    own_st_valid = 0;
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 4; i++) do_load(8'h50 + 8'(i), 4'd7, 3'b000);
    check("R10 no stall when filling", stall, 0);
    do_load(8'h54, 4'd7, 3'b000);
    check("R10 stall on overflow", stall, 1);
    read_chk("R10 overflow load dropped", 8'h54, 4'd7, 0);
    tick();
    check("R10 stall holds", stall, 1);
    do_commit();
    check("R11 commit clears stall", stall, 0);
    check("R11 commit no restart", restart, 0);
    read_chk("R11 table emptied", 8'h50, 4'd7, 0);
    do_fork();
    for (int i = 0; i < 5; i++) do_load(8'h60 + 8'(i), 4'd7, 3'b000);
    check("R10 stall in mp", stall, 1);
    do_res(1'b0);
    check("R10 stall released at exit", stall, 0);
    do_commit();
    do_fork();
    do_load(8'h70, 4'd8, 3'b000);
    do_store(8'h70, 4'd2);
    do_commit();
    check("R11 mp dropped", mp_mode, 0);
    tick();
    check("R11 pending dropped", restart, 0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_normal();
    t_kill_path();
    t_survivor_restart();
    t_nested();
    t_fork_limit();
    t_publish();
    t_overflow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule